// File: doc/BRIEF.md
# Flash Block Erase Sequencer

This block runs a complete block erase on a byte-command flash device and then proves the block is blank. It is the bus master during the whole operation. It issues single-cycle read and write strobes on a simple memory port, drives a one-cycle pulse to an external write-enable latch before every group of command writes, and pulses a clear to the bus bridge's byte-lane select at the start of each operation. A request is a block index plus a one-cycle `start`. The answer is a one-cycle `done` with a two-bit result.

The sequence runs in this order. The block first flushes the device's stale status and then aims the erase command pair at the middle of the chosen block. After that it waits and polls the device status until the ready bit comes up or a long timeout runs out. It then returns the device to array-read mode. If the device reported no erase error, the block reads every 32-bit word of the block and compares it against all ones. Every wait is a parameter counted in clock cycles, so the same RTL serves both the real timing and short simulation runs.

Top module: `flash_erase_seq`

## Requirements
- R1: While reset is held and afterwards, with no `start`, `done`, `busRd`, `busWr`, `gatePulse` and `laneClr` stay 0 and `result` is 0.
- R2: Each operation pulses `laneClr` (the request to reset the bridge lane select to lane 0) before its first bus read or write.
- R3: Before erasing, the block makes these accesses in this order: a read at HALF, a write of 0x50 at HALF, a read at MID, a write of 0x20 at MID, and a write of 0xD0 at MID. HALF is byte address 2^(BLOCK_SHIFT-1). MID is blkIdx*2^BLOCK_SHIFT + HALF.
- R4: Every command write happens exactly GATE_SETTLE+1 or GATE_SETTLE+2 cycles after the most recent `gatePulse`.
- R5: Status polls are reads at MID. The first poll comes ERASE_WAIT+POLL_GAP+1 cycles after the 0xD0 write. Consecutive polls are POLL_GAP+2 cycles apart. Polling stops at the first poll whose bit 7 is 1.
- R6: When polling ends, for any reason, the block writes 0xFF at MID.
- R7: If the last poll had bit 7 set and bit 5 set, the block writes 0x50 at HALF right after the 0xFF write. It then finishes with result 1 and makes no blank-check reads.
- R8: If the device reports no error, the block makes 2^(BLOCK_SHIFT-2) blank-check reads at ascending word addresses from blkIdx*2^BLOCK_SHIFT. When every word read back is 0xFFFFFFFF, it finishes with result 0.
- R9: The first blank-check word that is not 0xFFFFFFFF ends the operation with result 2. No further word is read.
- R10: If a poll finds bit 7 clear once ERASE_TIMEOUT cycles have passed since the 0xD0 write, polling stops. The 0xFF write follows, and the block finishes with result 3, with no blank-check reads and no 0x50 write.
- R11: `done` lasts exactly one cycle per operation. A `start` pulse while an operation is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request, sampled only when idle |
| blkIdx | input | BLK_W | Block to erase, captured with `start` |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 ok, 1 erase error, 2 blank-check mismatch, 3 timeout; valid with `done` |
| busAddr | output | BLK_W+BLOCK_SHIFT | Byte address of the current access |
| busWData | output | 8 | Command byte for a write |
| busWr | output | 1 | One-cycle write strobe |
| busRd | output | 1 | One-cycle read strobe |
| busRData | input | 32 | Read data, valid in the cycle after `busRd` |
| gatePulse | output | 1 | One-cycle pulse that opens the external write gate |
| laneClr | output | 1 | One-cycle pulse that resets the bridge lane select to lane 0 |

## Verification
The bench builds the block with 4 blocks of 256 bytes. A blank check is then 64 words, which keeps a fault in the very last word inside a short run. The write-gate settle is 3 cycles, the initial erase wait is 20, the poll gap is 5, the blank-check wait is 4 and the erase timeout is 200. With a 30-cycle device busy time, the poll loop goes around more than once before the ready bit appears. A hung device therefore reaches the timeout exit within a few hundred cycles, and the exact poll spacing and gate-to-write distances can be compared cycle by cycle.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;

  typedef enum logic [1:0] {
    RES_OK         = 2'd0,
    RES_ERASE_ERR  = 2'd1,
    RES_VERIFY_ERR = 2'd2,
    RES_TIMEOUT    = 2'd3
  } resCode_e;

  typedef enum logic [1:0] {CMD_CLEAR, CMD_SETUP, CMD_CONFIRM, CMD_ARRAY} cmdSel_e;
  typedef enum logic [1:0] {ADR_HALF, ADR_MID, ADR_WORD} adrSel_e;
  typedef enum logic [1:0] {DLY_SETTLE, DLY_ERASE, DLY_POLL, DLY_VERIFY} dlySel_e;

  localparam logic [7:0] CODE_CLEAR   = 8'h50;
  localparam logic [7:0] CODE_SETUP   = 8'h20;
  localparam logic [7:0] CODE_CONFIRM = 8'hD0;
  localparam logic [7:0] CODE_ARRAY   = 8'hFF;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic    rd;
    logic    wr;
    cmdSel_e cmd;
    adrSel_e adr;
    logic    dlyLoad;
    dlySel_e dlySel;
    logic    tmoClr;
    logic    capStat;
    logic    wordClr;
    logic    wordInc;
    logic    blkLoad;
  } seqCtl_t;

endpackage

// File: rtl/flash_erase_dp.sv
module flash_erase_dp
  import flash_erase_pkg::*;
#(
  parameter int BLK_W         = 6,
  parameter int BLOCK_SHIFT   = 16,
  parameter int GATE_SETTLE   = 1250,
  parameter int ERASE_WAIT    = 500000,
  parameter int POLL_GAP      = 500000,
  parameter int ERASE_TIMEOUT = 500000000,
  parameter int VERIFY_WAIT   = 500000
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  seqCtl_t                      ctl,
  input  logic [BLK_W-1:0]             blkIdx,
  input  logic [31:0]                  busRData,
  output logic [BLK_W+BLOCK_SHIFT-1:0] busAddr,
  output logic [7:0]                   busWData,
  output logic                         busRd,
  output logic                         busWr,
  output logic                         dlyDone,
  output logic                         tmoHit,
  output logic                         rdReady,
  output logic                         statErr,
  output logic                         wordOnes,
  output logic                         lastWord
);

  function automatic int maxOf(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int ADDR_W  = BLK_W + BLOCK_SHIFT;
  localparam int WIDX_W  = BLOCK_SHIFT - 2;
  localparam int DLY_MAX = maxOf(maxOf(GATE_SETTLE, ERASE_WAIT), maxOf(POLL_GAP, VERIFY_WAIT));
  localparam int DLY_W   = $clog2(DLY_MAX + 1);
  localparam int TMO_W   = $clog2(ERASE_TIMEOUT + 1);

  logic [BLK_W-1:0]  blkReg;
  logic [DLY_W-1:0]  dlyCnt;
  logic [DLY_W-1:0]  dlyValue;
  logic [TMO_W-1:0]  tmoCnt;
  logic [WIDX_W-1:0] wordIdx;
  logic              errBitReg;

  always_comb begin
    case (ctl.dlySel)
      DLY_SETTLE: dlyValue = DLY_W'(GATE_SETTLE);
      DLY_ERASE:  dlyValue = DLY_W'(ERASE_WAIT);
      DLY_POLL:   dlyValue = DLY_W'(POLL_GAP);
      default:    dlyValue = DLY_W'(VERIFY_WAIT);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      blkReg    <= '0;
      dlyCnt    <= '0;
      tmoCnt    <= '0;
      wordIdx   <= '0;
      errBitReg <= 1'b0;
    end else begin
      if (ctl.blkLoad) blkReg <= blkIdx;
      if (ctl.dlyLoad) dlyCnt <= dlyValue;
      else if (dlyCnt != '0) dlyCnt <= dlyCnt - 1'b1;
      if (ctl.tmoClr) tmoCnt <= '0;
      else if (tmoCnt != TMO_W'(ERASE_TIMEOUT)) tmoCnt <= tmoCnt + 1'b1;
      if (ctl.wordClr) wordIdx <= '0;
      else if (ctl.wordInc) wordIdx <= wordIdx + 1'b1;
      if (ctl.capStat) errBitReg <= busRData[5];
    end
  end

  assign dlyDone  = (dlyCnt <= DLY_W'(1));
  assign tmoHit   = (tmoCnt == TMO_W'(ERASE_TIMEOUT));
  assign rdReady  = busRData[7];
  assign statErr  = errBitReg;
  assign wordOnes = &busRData;
  assign lastWord = &wordIdx;

  always_comb begin
    case (ctl.adr)
      ADR_HALF: busAddr = {{BLK_W{1'b0}}, 1'b1, {(BLOCK_SHIFT-1){1'b0}}};
      ADR_MID:  busAddr = {blkReg, 1'b1, {(BLOCK_SHIFT-1){1'b0}}};
      default:  busAddr = {blkReg, wordIdx, 2'b00};
    endcase
    case (ctl.cmd)
      CMD_CLEAR:   busWData = CODE_CLEAR;
      CMD_SETUP:   busWData = CODE_SETUP;
      CMD_CONFIRM: busWData = CODE_CONFIRM;
      default:     busWData = CODE_ARRAY;
    endcase
  end

  assign busRd = ctl.rd;
  assign busWr = ctl.wr;

  logic unusedAddr;
  assign unusedAddr = ^ADDR_W;

endmodule

// File: rtl/flash_erase_ctrl.sv
module flash_erase_ctrl
  import flash_erase_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       dlyDone,
  input  logic       tmoHit,
  input  logic       rdReady,
  input  logic       statErr,
  input  logic       wordOnes,
  input  logic       lastWord,
  output seqCtl_t    ctl,
  output logic       gatePulse,
  output logic       laneClr,
  output logic       done,
  output logic [1:0] result
);

  typedef enum logic [4:0] {
    S_IDLE, S_LANE, S_RD_HALF, S_RD_HALF_W, S_GATE_A, S_SETL_A, S_CLR,
    S_RD_MID, S_RD_MID_W, S_GATE_B, S_SETL_B, S_SETUP, S_CONFIRM,
    S_ERASE_WAIT, S_POLL_GAP, S_POLL_RD, S_POLL_CAP, S_GATE_C, S_SETL_C,
    S_ARRAY, S_ERR_CLR, S_VFY_WAIT, S_VFY_RD, S_VFY_CAP, S_FIN
  } state_e;

  state_e   state, stateNxt;
  resCode_e resReg;
  resCode_e resVal;
  logic     resSet;
  logic     timedOut, tmoSet, tmoRst;

  always_comb begin
    stateNxt  = state;
    ctl       = '0;
    gatePulse = 1'b0;
    laneClr   = 1'b0;
    resSet    = 1'b0;
    resVal    = RES_OK;
    tmoSet    = 1'b0;
    tmoRst    = 1'b0;
    case (state)
      S_IDLE: if (start) begin
        ctl.blkLoad = 1'b1;
        tmoRst      = 1'b1;
        stateNxt    = S_LANE;
      end
      S_LANE: begin laneClr = 1'b1; stateNxt = S_RD_HALF; end
      S_RD_HALF: begin ctl.rd = 1'b1; ctl.adr = ADR_HALF; stateNxt = S_RD_HALF_W; end
      S_RD_HALF_W: stateNxt = S_GATE_A;
      S_GATE_A, S_GATE_B, S_GATE_C: begin
        gatePulse   = 1'b1;
        ctl.dlyLoad = 1'b1;
        ctl.dlySel  = DLY_SETTLE;
        stateNxt    = (state == S_GATE_A) ? S_SETL_A :
                      (state == S_GATE_B) ? S_SETL_B : S_SETL_C;
      end
      S_SETL_A: if (dlyDone) stateNxt = S_CLR;
      S_SETL_B: if (dlyDone) stateNxt = S_SETUP;
      S_SETL_C: if (dlyDone) stateNxt = S_ARRAY;
      S_CLR: begin
        ctl.wr = 1'b1; ctl.cmd = CMD_CLEAR; ctl.adr = ADR_HALF; stateNxt = S_RD_MID;
      end
      S_RD_MID: begin ctl.rd = 1'b1; ctl.adr = ADR_MID; stateNxt = S_RD_MID_W; end
      S_RD_MID_W: stateNxt = S_GATE_B;
      S_SETUP: begin
        ctl.wr = 1'b1; ctl.cmd = CMD_SETUP; ctl.adr = ADR_MID; stateNxt = S_CONFIRM;
      end
      S_CONFIRM: begin
        ctl.wr      = 1'b1;
        ctl.cmd     = CMD_CONFIRM;
        ctl.adr     = ADR_MID;
        ctl.tmoClr  = 1'b1;
        ctl.dlyLoad = 1'b1;
        ctl.dlySel  = DLY_ERASE;
        stateNxt    = S_ERASE_WAIT;
      end
      S_ERASE_WAIT: if (dlyDone) begin
        ctl.dlyLoad = 1'b1; ctl.dlySel = DLY_POLL; stateNxt = S_POLL_GAP;
      end
      S_POLL_GAP: if (dlyDone) stateNxt = S_POLL_RD;
      S_POLL_RD: begin ctl.rd = 1'b1; ctl.adr = ADR_MID; stateNxt = S_POLL_CAP; end
      S_POLL_CAP: begin
        ctl.capStat = 1'b1;
        if (rdReady) stateNxt = S_GATE_C;
        else if (tmoHit) begin tmoSet = 1'b1; stateNxt = S_GATE_C; end
        else begin ctl.dlyLoad = 1'b1; ctl.dlySel = DLY_POLL; stateNxt = S_POLL_GAP; end
      end
      S_ARRAY: begin
        ctl.wr = 1'b1; ctl.cmd = CMD_ARRAY; ctl.adr = ADR_MID;
        if (timedOut) begin resSet = 1'b1; resVal = RES_TIMEOUT; stateNxt = S_FIN; end
        else if (statErr) stateNxt = S_ERR_CLR;
        else begin
          ctl.dlyLoad = 1'b1; ctl.dlySel = DLY_VERIFY; ctl.wordClr = 1'b1;
          stateNxt = S_VFY_WAIT;
        end
      end
      S_ERR_CLR: begin
        ctl.wr = 1'b1; ctl.cmd = CMD_CLEAR; ctl.adr = ADR_HALF;
        resSet = 1'b1; resVal = RES_ERASE_ERR; stateNxt = S_FIN;
      end
      S_VFY_WAIT: if (dlyDone) stateNxt = S_VFY_RD;
      S_VFY_RD: begin ctl.rd = 1'b1; ctl.adr = ADR_WORD; stateNxt = S_VFY_CAP; end
      S_VFY_CAP: begin
        ctl.adr = ADR_WORD;
        if (!wordOnes) begin resSet = 1'b1; resVal = RES_VERIFY_ERR; stateNxt = S_FIN; end
        else if (lastWord) begin resSet = 1'b1; resVal = RES_OK; stateNxt = S_FIN; end
        else begin ctl.wordInc = 1'b1; stateNxt = S_VFY_RD; end
      end
      S_FIN: stateNxt = S_IDLE;
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      resReg   <= RES_OK;
      timedOut <= 1'b0;
    end else begin
      state <= stateNxt;
      if (resSet) resReg <= resVal;
      if (tmoRst) timedOut <= 1'b0;
      else if (tmoSet) timedOut <= 1'b1;
    end
  end

  assign done   = (state == S_FIN);
  assign result = resReg;

endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import flash_erase_pkg::*;
#(
  parameter int BLK_W         = 6,
  parameter int BLOCK_SHIFT   = 16,
  parameter int GATE_SETTLE   = 1250,
  parameter int ERASE_WAIT    = 500000,
  parameter int POLL_GAP      = 500000,
  parameter int ERASE_TIMEOUT = 500000000,
  parameter int VERIFY_WAIT   = 500000
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         start,
  input  logic [BLK_W-1:0]             blkIdx,
  output logic                         done,
  output logic [1:0]                   result,
  output logic [BLK_W+BLOCK_SHIFT-1:0] busAddr,
  output logic [7:0]                   busWData,
  output logic                         busWr,
  output logic                         busRd,
  input  logic [31:0]                  busRData,
  output logic                         gatePulse,
  output logic                         laneClr
);

  seqCtl_t ctl;
  logic    dlyDone, tmoHit, rdReady, statErr, wordOnes, lastWord;

  flash_erase_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .dlyDone(dlyDone), .tmoHit(tmoHit), .rdReady(rdReady), .statErr(statErr),
    .wordOnes(wordOnes), .lastWord(lastWord),
    .ctl(ctl), .gatePulse(gatePulse), .laneClr(laneClr),
    .done(done), .result(result)
  );

  flash_erase_dp #(
    .BLK_W(BLK_W), .BLOCK_SHIFT(BLOCK_SHIFT), .GATE_SETTLE(GATE_SETTLE),
    .ERASE_WAIT(ERASE_WAIT), .POLL_GAP(POLL_GAP),
    .ERASE_TIMEOUT(ERASE_TIMEOUT), .VERIFY_WAIT(VERIFY_WAIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .blkIdx(blkIdx), .busRData(busRData),
    .busAddr(busAddr), .busWData(busWData), .busRd(busRd), .busWr(busWr),
    .dlyDone(dlyDone), .tmoHit(tmoHit), .rdReady(rdReady), .statErr(statErr),
    .wordOnes(wordOnes), .lastWord(lastWord)
  );

endmodule

// File: rtl/flash_erase_chk.sv
module flash_erase_chk #(
  parameter int GATE_SETTLE = 1250
) (
  input logic clk,
  input logic rstN,
  input logic done,
  input logic busRd,
  input logic busWr,
  input logic gatePulse,
  input logic laneClr
);

  localparam int AGE_MAX = GATE_SETTLE + 3;
  localparam int AGE_W   = $clog2(AGE_MAX + 1);

  logic [AGE_W-1:0] gateAge;
  logic             laneOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gateAge <= AGE_W'(AGE_MAX);
      laneOk  <= 1'b0;
    end else begin
      if (gatePulse) gateAge <= AGE_W'(1);
      else if (gateAge != AGE_W'(AGE_MAX)) gateAge <= gateAge + 1'b1;
      if (laneClr) laneOk <= 1'b1;
      else if (done) laneOk <= 1'b0;
    end
  end

  // R4
  gate_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    busWr |-> (gateAge >= AGE_W'(GATE_SETTLE + 1) && gateAge <= AGE_W'(GATE_SETTLE + 2)));

  // R2
  lane_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRd || busWr) |-> laneOk);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R3
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busRd && busWr));

  // R11
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !(busRd || busWr || gatePulse));

endmodule

bind flash_erase_seq flash_erase_chk #(.GATE_SETTLE(GATE_SETTLE)) u_chk (
  .clk(clk), .rstN(rstN), .done(done), .busRd(busRd), .busWr(busWr),
  .gatePulse(gatePulse), .laneClr(laneClr)
);

// File: tb/flash_erase_seq_bench.sv
`timescale 1ns/1ps
module flash_erase_seq_bench;

  localparam int BLK_W = 2, SHIFT = 8, SETTLE = 3, EWAIT = 20, PGAP = 5;
  localparam int TMO = 200, VWAIT = 4, BUSY = 30;
  localparam int ADDR_W = BLK_W + SHIFT;
  localparam int BLK_BYTES = 1 << SHIFT;
  localparam int WORDS = BLK_BYTES / 4;
  localparam int HALF = BLK_BYTES / 2;
  localparam int MEM_BYTES = 1 << ADDR_W;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic [BLK_W-1:0] blkIdx = '0;
  logic done, busWr, busRd, gatePulse, laneClr;
  logic [1:0] result;
  logic [ADDR_W-1:0] busAddr;
  logic [7:0] busWData;
  logic [31:0] busRData = '0;

  always #10 clk = ~clk;

  flash_erase_seq #(
    .BLK_W(BLK_W), .BLOCK_SHIFT(SHIFT), .GATE_SETTLE(SETTLE), .ERASE_WAIT(EWAIT),
    .POLL_GAP(PGAP), .ERASE_TIMEOUT(TMO), .VERIFY_WAIT(VWAIT)
  ) u_flash_erase_seq (
    .clk(clk), .rstN(rstN), .start(start), .blkIdx(blkIdx), .done(done),
    .result(result), .busAddr(busAddr), .busWData(busWData), .busWr(busWr),
    .busRd(busRd), .busRData(busRData), .gatePulse(gatePulse), .laneClr(laneClr)
  );

  int nChecks = 0, nFail = 0, doneCount = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // behavioural flash
  logic [7:0] mem [MEM_BYTES];
  logic [7:0] flashStat = 8'h80;
  bit statusMode = 0, erasing = 0, pendSetup = 0, injErr = 0, injHang = 0;
  bit laneSeen = 0, confirmed = 0, arrayAfter = 0;
  int pendBlk = 0, eraseBlk = 0, busyLeft = 0, stuckOff = -1;
  int cyc = 0, sinceGate = 1000, laneBad = 0, gateBad = 0, pollBad = 0;
  int vAddrBad = 0, vReads = 0, firstGap = -1, lastPoll = 0, confirmCyc = 0;
  int wlogA[$], wlogD[$], preLog[$];

  always @(negedge clk) begin
    cyc++;
    if (sinceGate < 1000) sinceGate++;
    if (gatePulse) sinceGate = 0;
    if (laneClr) begin
      laneSeen = 1; wlogA.delete(); wlogD.delete(); preLog.delete();
      vReads = 0; vAddrBad = 0; pollBad = 0; gateBad = 0; firstGap = -1;
      confirmed = 0; arrayAfter = 0;
    end
    if ((busRd || busWr) && !laneSeen) laneBad++;
    if (done) laneSeen = 0;
    if (erasing && !injHang) begin
      if (busyLeft > 0) busyLeft--;
      if (busyLeft == 0) begin
        erasing = 0;
        if (injErr) flashStat = 8'hA0;
        else begin
          for (int i = 0; i < BLK_BYTES; i++) mem[eraseBlk*BLK_BYTES + i] = 8'hFF;
          if (stuckOff >= 0) mem[eraseBlk*BLK_BYTES + stuckOff] = 8'h00;
          flashStat = 8'h80;
        end
      end
    end
    if (busWr) begin
      if (sinceGate < SETTLE + 1 || sinceGate > SETTLE + 2) gateBad++;
      wlogA.push_back(int'(busAddr)); wlogD.push_back(int'(busWData));
      case (busWData)
        8'h50: begin flashStat = flashStat & 8'hC7; pendSetup = 0; end
        8'h20: begin pendSetup = 1; pendBlk = int'(busAddr) >> SHIFT; end
        8'hD0: begin
          if (pendSetup && pendBlk == (int'(busAddr) >> SHIFT)) begin
            erasing = 1; eraseBlk = pendBlk; busyLeft = BUSY; flashStat = 8'h00;
            statusMode = 1; confirmed = 1; confirmCyc = cyc;
          end
          pendSetup = 0;
        end
        8'hFF: begin statusMode = 0; pendSetup = 0; if (confirmed) arrayAfter = 1; end
        default: pendSetup = 0;
      endcase
    end
    if (busRd) begin
      int a;
      a = int'(busAddr) & ~3;
      if (statusMode) begin
        busRData = {4{flashStat}};
        if (firstGap < 0) firstGap = cyc - confirmCyc;
        else if (cyc - lastPoll != PGAP + 2) pollBad++;
        lastPoll = cyc;
      end else begin
        busRData = {mem[a+3], mem[a+2], mem[a+1], mem[a]};
        if (!confirmed) preLog.push_back(int'(busAddr));
        else if (arrayAfter) begin
          if (int'(busAddr) != eraseBlk*BLK_BYTES + 4*vReads) vAddrBad++;
          vReads++;
        end
      end
    end
  end

  // scoreboard
  typedef struct { int blk; int code; int vr; } expItem_t;
  expItem_t expQ[$];

  initial begin
    expItem_t e;
    int mid;
    forever begin
      @(negedge clk);
      if (done) begin
        if (expQ.size() == 0) chk(0, "R11 unexpected done", 1, 0);
        else begin
          e = expQ.pop_front();
          mid = e.blk*BLK_BYTES + HALF;
          chk(int'(result) == e.code, "R7/R8/R9/R10 result", int'(result), e.code);
          chk(laneBad == 0, "R2 lane clear first", laneBad, 0);
          chk(gateBad == 0, "R4 gate window", gateBad, 0);
          chk(preLog.size() == 2 && preLog[0] == HALF && preLog[1] == mid,
              "R3 dummy reads", preLog.size() > 1 ? preLog[1] : -1, mid);
          chk(wlogA.size() >= 4 && wlogA[0] == HALF && wlogD[0] == 8'h50 &&
              wlogA[1] == mid && wlogD[1] == 8'h20 && wlogA[2] == mid && wlogD[2] == 8'hD0,
              "R3 command order", wlogA.size() > 2 ? wlogD[2] : -1, 8'hD0);
          chk(wlogA.size() >= 4 && wlogA[3] == mid && wlogD[3] == 8'hFF,
              "R6 array mode write", wlogA.size() > 3 ? wlogD[3] : -1, 8'hFF);
          chk(wlogA.size() == ((e.code == 1) ? 5 : 4), "R7 R10 write count",
              wlogA.size(), (e.code == 1) ? 5 : 4);
          if (e.code == 1)
            chk(wlogA.size() == 5 && wlogA[4] == HALF && wlogD[4] == 8'h50,
                "R7 error clear", wlogA.size() > 4 ? wlogA[4] : -1, HALF);
          chk(firstGap == EWAIT + PGAP + 1, "R5 first poll", firstGap, EWAIT + PGAP + 1);
          chk(pollBad == 0, "R5 poll spacing", pollBad, 0);
          chk(vReads == e.vr, "R8 R9 blank-check reads", vReads, e.vr);
          chk(vAddrBad == 0, "R8 word addresses", vAddrBad, 0);
          doneCount++;
          @(negedge clk);
          chk(done == 1'b0, "R11 done width", int'(done), 0);
        end
      end
    end
  end

  task automatic runOp(int blk, bit err, bit hang, int stuck, int code, int vr, bit poke);
    expItem_t e;
    int n0;
    @(negedge clk);
    injErr = err; injHang = hang; stuckOff = stuck;
    e.blk = blk; e.code = code; e.vr = vr;
    expQ.push_back(e);
    n0 = doneCount;
    blkIdx = BLK_W'(blk); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (10) @(negedge clk);
      blkIdx = BLK_W'(blk + 1); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (doneCount == n0) @(negedge clk);
    repeat (30) @(negedge clk);
    chk(doneCount == n0 + 1, "R11 one done per op", doneCount - n0, 1);
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    nFail++; nChecks++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    for (int i = 0; i < MEM_BYTES; i++) mem[i] = 8'(i) ^ 8'h5A;
    repeat (3) @(negedge clk);
    chk(done == 0 && busRd == 0 && busWr == 0 && gatePulse == 0 && laneClr == 0,
        "R1 idle in reset", int'(busRd | busWr | done | gatePulse | laneClr), 0);
    rstN = 1'b1;
    repeat (20) @(negedge clk);
    chk(done == 0 && busRd == 0 && busWr == 0 && result == 2'd0,
        "R1 idle after reset", int'(result), 0);
    runOp(1, 0, 0, -1, 0, WORDS, 0);        // R8 clean erase
    runOp(3, 0, 0, -1, 0, WORDS, 1);        // R11 start ignored while busy
    runOp(2, 1, 0, -1, 1, 0, 0);            // R7 erase error bit
    runOp(0, 0, 0, 8'h25, 2, 10, 0);        // R9 mismatch in word 9
    runOp(3, 0, 0, BLK_BYTES - 1, 2, WORDS, 0); // R9 mismatch in last word
    runOp(2, 0, 1, -1, 3, 0, 0);            // R10 device never ready
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule